// File: doc/BRIEF.md
# Per-CPU Self/Other Inter-Processor Interrupt Unit

This block keeps, for every CPU of a cluster, two inter-processor interrupt kinds: an "other" IPI that one CPU raises on a set of CPUs, and a "self" IPI. Each kind has a pending bit and a mask bit per CPU. Software reaches them over a 32-bit register bus. The bus carries a CPU-id sideband, which selects the requesting CPU's "this-CPU" register view. An explicit per-CPU view reaches any CPU's state, whatever the requester.

A CPU collects its IPIs by reading its event register. That read returns an IPI type code and a number naming the kind. It also masks the delivered kind automatically, so software must clear the mask again to receive the next one. The pending bit stays set until it is acknowledged.

A hardware-interrupt-pending input per CPU takes priority. While it is high, an event read from that CPU delivers no IPI. A per-CPU request output flags any pending, unmasked IPI, so that the event logic next to this block can raise the CPU's interrupt line.

Top module: `ipi_unit`

## Requirements
- R1: After reset no IPI is pending, both kinds are masked on every CPU, `ipi_req_o` is 0 and `rdata_o` is 0.
- R2: A write to 0x2008 with bit n set (n < NUM_CPU) makes the "other" IPI pending on CPU n, and several bits act together. Bit 31 of the same write makes the "self" IPI pending on the requesting CPU.
- R3: Writing 0x2024 masks, and writing 0x2028 unmasks, the requester's kinds. Bit 0 selects "other" and bit 31 selects "self".
- R4: Writing 0x200C clears the requester's pending kinds selected by bit 0 ("other") and bit 31 ("self").
- R5: The addresses 0x5008 (raise), 0x500C (clear pending), 0x5024 (mask) and 0x5028 (unmask), each plus cpu<<7, act on that CPU's kinds with the same bit 0 / bit 31 selection, whatever `cpu_id_i` is.
- R6: A read of 0x2004 returns, on `rdata_o` in the following cycle, the word 0x0004_0001 for a deliverable "other" IPI or 0x0004_0002 for "self" (type 4 in bits 23:16, number in bits 15:0). "Other" wins when both are deliverable, and the word is 0 when neither is.
- R7: Delivering a kind masks it on that CPU. Its pending bit stays set, so it is delivered again after it is unmasked, unless it has been acknowledged in the meantime.
- R8: While `hw_irq_i` of the requesting CPU is 1, an event read returns 0 and changes no state. The same input of another CPU has no effect on the read.
- R9: `ipi_req_o[c]` is 1 exactly when CPU c has a pending kind that is unmasked.
- R10: A kind that becomes pending while masked stays pending and is delivered once unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_id_i | input | CPU_W | Requesting CPU for the current bus access |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 16 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| hw_irq_i | input | NUM_CPU | Hardware interrupt pending, per CPU |
| rdata_o | output | 32 | Event read data, one cycle after the read |
| ipi_req_o | output | NUM_CPU | Pending-and-unmasked IPI request, per CPU |

## Verification
The assertions assume a single bus operation per cycle, so a write strobe and a read strobe are never high together. They also assume that `cpu_id_i` names an existing CPU whenever a strobe is high. The rule that requests rise only after writes further assumes that no state changes on a cycle without a write.

The stimulus keeps to these rules. Each bus task drives one strobe for exactly one cycle with an in-range requester. The bench sweeps every CPU, every pending pattern of the two kinds and both view styles. It predicts event words and request bits with a small arithmetic model of the requirements.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [15:0] ADDR_EVENT = 16'h2004;
  localparam logic [15:0] ADDR_SEND  = 16'h2008;
  localparam logic [15:0] ADDR_ACK   = 16'h200C;
  localparam logic [15:0] ADDR_MSET  = 16'h2024;
  localparam logic [15:0] ADDR_MCLR  = 16'h2028;
  localparam logic [3:0]  PCPU_PAGE  = 4'h5;
  localparam logic [6:0]  PCPU_SET   = 7'h08;
  localparam logic [6:0]  PCPU_CLR   = 7'h0C;
  localparam logic [6:0]  PCPU_MSET  = 7'h24;
  localparam logic [6:0]  PCPU_MCLR  = 7'h28;
  localparam logic [7:0]  EVT_TYPE_IPI = 8'd4;

  // bit 0 = other, bit 1 = self
  typedef struct packed {
    logic [1:0] pset;
    logic [1:0] pclr;
    logic [1:0] mset;
    logic [1:0] mclr;
  } ipi_op_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic                     wr_en_i,
  input  logic [CPU_W-1:0]         cpu_id_i,
  input  logic [15:0]              addr_i,
  input  logic [31:0]              wdata_i,
  output ipi_op_t [NUM_CPU-1:0]    ops_o
);
  logic [1:0] kinds;
  logic       pcpu_page;
  logic [4:0] pcpu_idx;
  logic [6:0] pcpu_reg;

  assign kinds     = {wdata_i[31], wdata_i[0]};
  assign pcpu_page = (addr_i[15:12] == PCPU_PAGE);
  assign pcpu_idx  = addr_i[11:7];
  assign pcpu_reg  = addr_i[6:0];

  always_comb begin
    ops_o = '0;
    if (wr_en_i) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (addr_i == ADDR_SEND) begin
          ops_o[c].pset[0] = wdata_i[c];
          if (cpu_id_i == CPU_W'(c)) ops_o[c].pset[1] = wdata_i[31];
        end
        if (cpu_id_i == CPU_W'(c)) begin
          if (addr_i == ADDR_ACK)  ops_o[c].pclr = kinds;
          if (addr_i == ADDR_MSET) ops_o[c].mset = kinds;
          if (addr_i == ADDR_MCLR) ops_o[c].mclr = kinds;
        end
        if (pcpu_page && pcpu_idx == 5'(c)) begin
          case (pcpu_reg)
            PCPU_SET:  ops_o[c].pset = ops_o[c].pset | kinds;
            PCPU_CLR:  ops_o[c].pclr = ops_o[c].pclr | kinds;
            PCPU_MSET: ops_o[c].mset = ops_o[c].mset | kinds;
            PCPU_MCLR: ops_o[c].mclr = ops_o[c].mclr | kinds;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ipi_op_t    op_i,
  input  logic [1:0] dlv_i,
  output logic [1:0] pend_o,
  output logic [1:0] msk_o,
  output logic       req_o
);
  logic [1:0] pend_q, msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      msk_q  <= '1;
    end else begin
      pend_q <= (pend_q | op_i.pset) & ~op_i.pclr;
      // delivery auto-masks; pending kept until acknowledged
      msk_q  <= (msk_q | op_i.mset | dlv_i) & ~op_i.mclr;
    end
  end

  assign pend_o = pend_q;
  assign msk_o  = msk_q;
  assign req_o  = |(pend_q & ~msk_q);
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CPU_W-1:0]   cpu_id_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [15:0]        addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_CPU-1:0] hw_irq_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CPU-1:0] ipi_req_o
);
  ipi_op_t [NUM_CPU-1:0]    ops;
  logic [NUM_CPU-1:0][1:0]  pend, msk, dlv;
  logic                     evt_rd, req_hw;
  logic [1:0]               req_avail, pick;
  logic [31:0]              evt_word;

  ipi_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_decode (
    .wr_en_i (wr_en_i),
    .cpu_id_i(cpu_id_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ops_o   (ops)
  );

  assign evt_rd = rd_en_i && (addr_i == ADDR_EVENT);

  always_comb begin
    req_avail = '0;
    req_hw    = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_id_i == CPU_W'(c)) begin
        req_avail = pend[c] & ~msk[c];
        req_hw    = hw_irq_i[c];
      end
    end
  end

  // other (number 1) ahead of self (number 2)
  always_comb begin
    pick = '0;
    if (evt_rd && !req_hw) begin
      if (req_avail[0])      pick = 2'b01;
      else if (req_avail[1]) pick = 2'b10;
    end
  end

  assign evt_word = (pick == 2'b00) ? 32'h0 : {8'h00, EVT_TYPE_IPI, 14'h0, pick};

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    assign dlv[g] = (cpu_id_i == CPU_W'(g)) ? pick : 2'b00;
    ipi_slot u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .op_i  (ops[g]),
      .dlv_i (dlv[g]),
      .pend_o(pend[g]),
      .msk_o (msk[g]),
      .req_o (ipi_req_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= evt_word;
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CPU_W-1:0]   cpu_id_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [15:0]        addr_i,
  input logic [NUM_CPU-1:0] hw_irq_i,
  input logic [31:0]        rdata_o,
  input logic [NUM_CPU-1:0] ipi_req_o
);
  logic evt_rd, hw_req, req_bit;
  assign evt_rd  = rd_en_i && (addr_i == ADDR_EVENT);
  assign hw_req  = hw_irq_i[cpu_id_i];
  assign req_bit = ipi_req_o[cpu_id_i];

  assert_evt_format_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != 32'h0) |-> (rdata_o[31:16] == 16'h0004 &&
                            (rdata_o[15:0] == 16'd1 || rdata_o[15:0] == 16'd2)));

  assert_hw_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(evt_rd && hw_req) |-> (rdata_o == 32'h0));

  assert_no_spont_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((ipi_req_o & ~$past(ipi_req_o)) == '0));

  assert_empty_only_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evt_rd && !hw_req) && rdata_o == 32'h0) |-> !$past(req_bit));

  assert_deliver_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evt_rd) && rdata_o != 32'h0) |-> $past(req_bit));
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cpu_id_i (cpu_id_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .hw_irq_i (hw_irq_i),
  .rdata_o  (rdata_o),
  .ipi_req_o(ipi_req_o)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam logic [15:0] A_EVT = 16'h2004, A_SEND = 16'h2008, A_ACK = 16'h200C,
                          A_MSET = 16'h2024, A_MCLR = 16'h2028;
  localparam logic [31:0] BOTH = 32'h8000_0001;

  logic clk = 0, rst_n = 0;
  logic [1:0]  cpu_id = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NCPU-1:0] hw_irq = '0;
  logic [31:0] rdata;
  logic [NCPU-1:0] ipi_req;

  int n_tests = 0, n_fail = 0;
  logic [1:0] mp [NCPU];
  logic [1:0] mm [NCPU];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_unit #(.NUM_CPU(NCPU)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_id_i(cpu_id), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .hw_irq_i(hw_irq), .rdata_o(rdata), .ipi_req_o(ipi_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NCPU-1:0] exp_req();
    logic [NCPU-1:0] r;
    for (int c = 0; c < NCPU; c++) r[c] = |(mp[c] & ~mm[c]);
    return r;
  endfunction

  task automatic check_req(input string tag);
    chk(tag, 32'(ipi_req), 32'(exp_req()));
  endtask

  task automatic wr(input int id, input logic [15:0] a, input logic [31:0] d);
    logic [1:0] k;
    int t;
    @(negedge clk);
    cpu_id = 2'(id); addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    k = {d[31], d[0]};
    if (a == A_SEND) begin
      for (int c = 0; c < NCPU; c++) if (d[c]) mp[c][0] = 1'b1;
      if (d[31]) mp[id][1] = 1'b1;
    end
    if (a == A_ACK)  mp[id] = mp[id] & ~k;
    if (a == A_MSET) mm[id] = mm[id] | k;
    if (a == A_MCLR) mm[id] = mm[id] & ~k;
    t = int'(a[11:7]);
    if (a[15:12] == 4'h5 && t < NCPU) begin
      case (a[6:0])
        7'h08: mp[t] = mp[t] | k;
        7'h0C: mp[t] = mp[t] & ~k;
        7'h24: mm[t] = mm[t] | k;
        7'h28: mm[t] = mm[t] & ~k;
        default: ;
      endcase
    end
  endtask

  task automatic evt(input int id, input logic [NCPU-1:0] hv, input string tag);
    logic [1:0]  av;
    logic [31:0] exp;
    @(negedge clk);
    cpu_id = 2'(id); addr = A_EVT; hw_irq = hv; rd_en = 1;
    @(negedge clk);
    rd_en = 0; hw_irq = '0;
    av = mp[id] & ~mm[id];
    exp = 32'h0;
    if (!hv[id]) begin
      if (av[0])      begin exp = 32'h0004_0001; mm[id][0] = 1'b1; end
      else if (av[1]) begin exp = 32'h0004_0002; mm[id][1] = 1'b1; end
    end
    chk(tag, rdata, exp);
  endtask

  function automatic logic [15:0] pcpu(input int c, input logic [15:0] base);
    return base + 16'(c << 7);
  endfunction

  initial begin
    for (int c = 0; c < NCPU; c++) begin mp[c] = 2'b00; mm[c] = 2'b11; end
    repeat (3) @(negedge clk);
    chk("R1 reset req", 32'(ipi_req), 32'h0);
    chk("R1 reset rdata", rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // masked by default: pending must not request (R1, R10)
    wr(0, A_SEND, 32'h0000_000F);
    check_req("R1 masked after reset");
    for (int c = 0; c < NCPU; c++) evt(c, '0, "R1 event empty while masked");
    for (int c = 0; c < NCPU; c++) wr(0, pcpu(c, 16'h500C), BOTH);
    check_req("R5 per-cpu clear");

    for (int c = 0; c < NCPU; c++) begin
      for (int p = 0; p < 4; p++) begin
        int r;
        r = (c + 1) % NCPU;
        if (c % 2 == 0) wr(c, A_MSET, BOTH);               // R3
        else            wr(r, pcpu(c, 16'h5024), BOTH);    // R5
        check_req("R3 mask set");
        if (p[0]) wr(r, A_SEND, 32'(1) << c);              // R2 other
        if (p[1]) begin
          if (c % 2 == 0) wr(c, A_SEND, 32'h8000_0000);    // R2 self
          else            wr(r, pcpu(c, 16'h5008), 32'h8000_0000); // R5
        end
        check_req("R10 pending held while masked");
        wr(c, A_MCLR, 32'h0000_0001);
        check_req("R3 unmask other only");
        wr(c, A_MCLR, 32'h8000_0000);
        check_req("R9 request after unmask");
        evt(c, NCPU'(1) << c, "R8 hw pending blocks ipi");
        check_req("R8 no state change");
        evt(c, ~(NCPU'(1) << c), "R8 other cpu hw ignored / R6");
        check_req("R7 auto-mask on delivery");
        evt(c, '0, "R6 second kind");
        evt(c, '0, "R7 all masked reads empty");
        check_req("R9 after deliveries");
        wr(c, A_MCLR, BOTH);
        check_req("R7 pending kept");
        evt(c, '0, "R7 redelivery after unmask");
        wr(c, A_MCLR, BOTH);
        wr(c, A_ACK, (p == 3) ? 32'h0000_0001 : BOTH);     // R4
        check_req("R4 ack clears");
        evt(c, '0, "R4 after ack");
        wr(r, pcpu(c, 16'h500C), BOTH);
        check_req("R5 clear via view");
      end
    end
    // multi-target send (R2)
    for (int c = 0; c < NCPU; c++) wr(c, A_MCLR, BOTH);
    wr(2, A_SEND, 32'h0000_000A);
    check_req("R2 multi-bit send");
    for (int c = 0; c < NCPU; c++) evt(c, '0, "R2 multi-bit delivery");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule